// File: doc/BRIEF.md
# Byte-Serial SPI Port with Register Access

This block is a byte-wide serial peripheral port that a processor drives through three small registers: control, status and data. It can run as the clock-producing side of the link, or as the clock-following side. As the clock-producing side, one write to the data register sends one byte out and takes one byte in. As the clock-following side, the block watches an external clock and a select input, and both are sampled with the system clock. Every finished byte raises a completion flag. The flag can also drive an interrupt request.

The link uses a single fixed timing mode. The serial clock idles low. Data moves most significant bit first. Outgoing data changes after a falling clock edge, and incoming data is taken at a rising edge. When the block produces the clock, the serial clock runs at the system clock divided by `CLK_DIV`. There is no select output: software drives the select line through an ordinary general-purpose pin.

Registers are chosen with `reg_sel`: 0 is control, 1 is status and 2 is data. Control bit 0 enables the block, bit 1 selects clock-producing operation and bit 2 enables the interrupt. Control reads back in bits 2:0. In status, bit 7 is the completion flag and bit 6 is the write-collision bit. Reading the data register returns the last received byte.

Top module: `spi_port`

## Requirements
- R1: After reset, control and status read as 0, `irq` is low and all three output enables are low.
- R2: When the block is enabled in clock-producing mode and is idle, a data-register write starts a transfer. `sck_o` then runs with 2 system clocks low and 2 high per bit, gives exactly 8 rising edges, and returns low.
- R3: The outgoing byte appears on `mosi_o` most significant bit first. Its bit 7 is present before the first rising edge, and each later bit appears after a falling edge. `miso_i` is taken at each rising edge and assembled most significant bit first.
- R4: The completion flag (status bit 7) is set on the clock edge that ends the eighth bit. `irq` equals the flag ANDed with control bit 2.
- R5: The received byte stays readable at the data register after the transfer ends. A later completion that comes before it is read replaces it.
- R6: A status read made while the flag is set, followed by any data-register access, clears the flag and the collision bit. A data access on its own does not clear them. A one-cycle `irq_ack` clears the flag. If a completion falls in the same cycle as a clear, the flag stays set.
- R7: A data write during an active transfer is discarded. The byte in flight continues unchanged, and status bit 6 is set.
- R8: In clock-producing mode, `ss_i` has no effect on transfers.
- R9: When the block is enabled in clock-producing mode, `sck_oe` and `mosi_oe` are high and `miso_oe` is low. In clock-following mode, `sck_oe` and `mosi_oe` are low and `miso_oe` follows the inverse of `ss_i`. When the block is disabled, all three are low.
- R10: In clock-following mode with `ss_i` high, clock edges shift nothing and set no flag, and a data write is still loaded for transmission.
- R11: In clock-following mode with `ss_i` low, each bit is taken from `mosi_i` on the sampled rising edge of `sck_i`. The loaded byte leaves on `miso_o` most significant bit first. The flag is set after 8 sampled falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears the completion flag |
| sck_i | input | 1 | Serial clock in (clock-following mode) |
| sck_o | output | 1 | Serial clock out |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in (clock-following mode) |
| mosi_o | output | 1 | Serial data out (clock-producing mode) |
| mosi_oe | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | Serial data in (clock-producing mode) |
| miso_o | output | 1 | Serial data out (clock-following mode) |
| miso_oe | output | 1 | Output enable for miso_o |
| ss_i | input | 1 | Select input, active low |

## Verification
Two events can fall in the same cycle: completion of the eighth bit and a request to clear the completion flag. A data write during a transfer can also coincide with completion. The bench watches its reference model and raises `irq_ack` for exactly the cycle whose closing edge ends the byte. It then expects the flag to read back as set, because setting has priority over clearing. The same model also predicts that a data write landing on that edge counts as a collision. Every other clock edge is compared pin by pin against the model.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_DATA = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic ie;
      logic mst;
      logic en;
   } ctrl_t;

   localparam int CTRL_BITS = 3;

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_port_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_port_mclk.sv
module spi_port_mclk #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic rise_evt,
   output logic fall_evt
);

   localparam int HALF = CLK_DIV / 2;
   localparam int PW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("spi_port_mclk: CLK_DIV must be even and at least 2");
   end

   logic [PW-1:0] ph;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                          ph <= '0;
      else if (!run)                       ph <= '0;
      else if (ph == PW'(CLK_DIV - 1))     ph <= '0;
      else                                 ph <= ph + 1'b1;

   assign sck      = run && (ph >= PW'(HALF));
   assign rise_evt = run && (ph == PW'(HALF - 1));
   assign fall_evt = run && (ph == PW'(CLK_DIV - 1));

endmodule

// File: rtl/spi_port.sv
module spi_port
   import spi_port_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   input  logic              irq_ack,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              mosi_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              miso_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              ss_i
);

   localparam int CW      = $clog2(DATA_W);
   localparam int ST_DONE = DATA_W - 1;
   localparam int ST_COLL = DATA_W - 2;

   if (DATA_W < CTRL_BITS || DATA_W < 3) begin : g_bad_width
      $error("spi_port: DATA_W too small for the register layout");
   end

   reg_sel_e          sel_e;
   ctrl_t             ctrl;
   logic              done_f, coll_f, armed, m_busy, rxb, sck_q;
   logic [DATA_W-1:0] shreg, rxbuf;
   logic [CW-1:0]     bitcnt;
   logic              ss_s, mosi_s, sck_s;
   logic              m_sck, m_rise, m_fall;
   logic              is_mst, is_slv, sel;
   logic              s_rise, s_fall, smp_evt, sft_evt, smp_bit, byte_done;
   logic              busy, wr_data, rd_data, rd_stat, load, collide, clr_seq;
   logic [DATA_W-1:0] next_sh;

   assign sel_e = reg_sel_e'(reg_sel);

   // pin synchronisers for clock-following mode (select resets inactive high)
   spi_port_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ss_i, mosi_i, sck_i}),
      .q({ss_s, mosi_s, sck_s})
   );

   spi_port_mclk #(.CLK_DIV(CLK_DIV)) u_mclk (
      .clk(clk), .rst_n(rst_n), .run(m_busy),
      .sck(m_sck), .rise_evt(m_rise), .fall_evt(m_fall)
   );

   assign is_mst  = ctrl.en &  ctrl.mst;
   assign is_slv  = ctrl.en & ~ctrl.mst;
   assign sel     = is_slv & ~ss_s;
   assign s_rise  = sel &  sck_s & ~sck_q;
   assign s_fall  = sel & ~sck_s &  sck_q;

   assign smp_evt   = is_mst ? m_rise : s_rise;
   assign sft_evt   = is_mst ? m_fall : s_fall;
   assign smp_bit   = is_mst ? miso_i : mosi_s;
   assign byte_done = sft_evt && (bitcnt == CW'(DATA_W - 1));
   assign next_sh   = {shreg[DATA_W-2:0], rxb};

   assign busy    = m_busy | (sel & (bitcnt != '0));
   assign wr_data = wr_en & (sel_e == SEL_DATA);
   assign rd_data = rd_en & (sel_e == SEL_DATA);
   assign rd_stat = rd_en & (sel_e == SEL_STAT);
   assign load    = wr_data & ~busy;
   assign collide = wr_data &  busy;
   assign clr_seq = armed & (wr_data | rd_data);

   // shift path shared by both modes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         rxbuf  <= '0;
         rxb    <= 1'b0;
         bitcnt <= '0;
         m_busy <= 1'b0;
         sck_q  <= 1'b0;
      end else begin
         sck_q <= sck_s;
         if (load) begin
            shreg  <= wdata;
            bitcnt <= '0;
            if (is_mst) m_busy <= 1'b1;
         end else begin
            if (smp_evt) rxb <= smp_bit;
            if (sft_evt) begin
               shreg  <= next_sh;
               bitcnt <= byte_done ? '0 : bitcnt + 1'b1;
               if (byte_done) begin
                  rxbuf  <= next_sh;
                  m_busy <= 1'b0;
               end
            end
         end
         if (!is_mst)         m_busy <= 1'b0;
         if (!sel && !is_mst) bitcnt <= '0;
      end
   end

   // control and status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         done_f <= 1'b0;
         coll_f <= 1'b0;
         armed  <= 1'b0;
      end else begin
         if (wr_en && sel_e == SEL_CTRL) ctrl <= ctrl_t'(wdata[CTRL_BITS-1:0]);
         if (rd_stat && done_f) armed <= 1'b1;
         if (clr_seq)           armed <= 1'b0;
         if (clr_seq || irq_ack) done_f <= 1'b0;
         if (byte_done)          done_f <= 1'b1;
         if (clr_seq) coll_f <= 1'b0;
         if (collide) coll_f <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      case (sel_e)
         SEL_CTRL: rdata[CTRL_BITS-1:0] = ctrl;
         SEL_STAT: begin
            rdata[ST_DONE] = done_f;
            rdata[ST_COLL] = coll_f;
         end
         SEL_DATA: rdata = rxbuf;
         default:  rdata = '0;
      endcase
   end

   assign irq     = done_f & ctrl.ie;
   assign sck_o   = m_sck;
   assign mosi_o  = shreg[DATA_W-1];
   assign miso_o  = shreg[DATA_W-1];
   assign sck_oe  = is_mst;
   assign mosi_oe = is_mst;
   assign miso_oe = is_slv & ~ss_i;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic mst,
   input logic ie,
   input logic ss_i,
   input logic sck_o,
   input logic sck_oe,
   input logic mosi_oe,
   input logic miso_oe,
   input logic irq,
   input logic done_f,
   input logic coll_f,
   input logic m_busy,
   input logic busy,
   input logic wr_data,
   input logic byte_done
);

   // R9
   mst_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mst) |-> (sck_oe && mosi_oe && !miso_oe));

   // R9
   slv_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !mst && ss_i) |-> (!sck_oe && !mosi_oe && !miso_oe));

   // R1
   off_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !(sck_oe || mosi_oe || miso_oe));

   // R4
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done_f && ie));

   // R2
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !m_busy |-> !sck_o);

   // R4
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_f) |-> $past(byte_done));

   // R7
   coll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && busy) |=> coll_f);

endmodule

bind spi_port spi_port_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .en(ctrl.en), .mst(ctrl.mst), .ie(ctrl.ie),
   .ss_i(ss_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
   .irq(irq), .done_f(done_f), .coll_f(coll_f),
   .m_busy(m_busy), .busy(busy), .wr_data(wr_data), .byte_done(byte_done)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic       wr_en = 1'b0, rd_en = 1'b0, irq_ack = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
   logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_i = 1'b1;

   int vectors = 0, fails = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_port u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .irq(irq), .irq_ack(irq_ack),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
      .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_i(ss_i)
   );

   task automatic chk(input int act, input int exp, input string tag);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model (clock-producing mode) ----------------
   bit       model_on = 0;
   bit       m_en, m_mst, m_ie, m_busy, m_rxb, m_done, m_coll, m_armed;
   int       m_cyc;
   bit [7:0] m_sh, m_rx;

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_en, m_mst, m_ie, m_busy, m_rxb, m_done, m_coll, m_armed} = '0;
         m_cyc = 0; m_sh = 0; m_rx = 0;
      end else begin
         automatic bit busy_now = m_busy;
         automatic bit wrd = wr_en && reg_sel == 2'd2;
         automatic bit rdd = rd_en && reg_sel == 2'd2;
         automatic bit clr = m_armed && (wrd || rdd);
         automatic bit fin = 0;
         if (busy_now) begin
            if (m_cyc % DIV == DIV/2 - 1) m_rxb = miso_i;
            if (m_cyc % DIV == DIV - 1) begin
               m_sh = {m_sh[6:0], m_rxb};
               if (m_cyc == 8*DIV - 1) begin fin = 1; m_busy = 0; m_rx = m_sh; end
            end
            m_cyc++;
         end
         if (rd_en && reg_sel == 2'd1 && m_done) m_armed = 1;
         if (clr) m_armed = 0;
         if (clr || irq_ack) m_done = 0;
         if (fin) m_done = 1;
         if (clr) m_coll = 0;
         if (wrd && busy_now) m_coll = 1;
         if (wrd && !busy_now) begin
            m_sh = wdata;
            if (m_en && m_mst) begin m_busy = 1; m_cyc = 0; end
         end
         if (wr_en && reg_sel == 2'd0) {m_ie, m_mst, m_en} = wdata[2:0];
      end
   end

   // per-clock comparison (R2 R3 R4)
   always @(negedge clk) begin
      if (model_on && rst_n) begin
         chk(sck_o, (m_busy && (m_cyc % DIV) >= DIV/2), "R2 sck_o");
         if (m_busy) chk(mosi_o, m_sh[7], "R3 mosi_o");
         chk(irq, (m_done && m_ie), "R4 irq");
      end
   end

   // clock-producing side: drive miso from a bench pattern
   int nc = 0;
   always @(negedge clk) begin
      nc++;
      if (model_on) miso_i <= nc[1] ^ nc[3];
   end

   int       rise_cnt = 0;
   bit [7:0] mcap = 0;
   always @(posedge sck_o) begin
      rise_cnt++;
      mcap = {mcap[6:0], mosi_o};
   end

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk); reg_sel = s; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      @(negedge clk); reg_sel = s; rd_en = 1'b1;
      #1 v = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400 && m_busy; i++) @(negedge clk);
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic slv_bit(input logic b, output logic so);
      @(negedge clk); mosi_i = b;
      repeat (7) @(negedge clk);
      so = miso_o; sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v, cap, first;
      logic       so;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); chk(v, 8'h00, "R1 ctrl reset");
      rd(2'd1, v); chk(v, 8'h00, "R1 status reset");
      chk(irq, 0, "R1 irq reset");
      chk({sck_oe, mosi_oe, miso_oe}, 3'b000, "R1 oe reset");

      model_on = 1;
      wr(2'd0, 8'h07);
      rd(2'd0, v); chk(v, 8'h07, "R9 ctrl readback");
      chk({sck_oe, mosi_oe, miso_oe}, 3'b110, "R9 master pins");

      // R2 R3 R4 R5 basic transfer
      rise_cnt = 0;
      wr(2'd2, 8'hA5);
      wait_idle();
      @(negedge clk);
      chk(rise_cnt, 8, "R2 sck rising edges");
      chk(mcap, 8'hA5, "R3 mosi byte msb first");
      chk(irq, 1, "R4 irq after byte");
      rd(2'd2, v); chk(v, m_rx, "R6 data read alone keeps flag (rx)");
      rd(2'd1, v); chk(v[7], 1, "R6 flag survives data read without status read");
      rd(2'd2, v); chk(v, m_rx, "R5 rx byte held after transfer");
      rd(2'd1, v); chk(v, 8'h00, "R6 status cleared by sequence");

      // R7 collision
      wr(2'd2, 8'h3C);
      repeat (5) @(negedge clk);
      wr(2'd2, 8'hFF);
      rd(2'd1, v); chk(v[6], 1, "R7 collision bit");
      wait_idle();
      @(negedge clk);
      chk(mcap, 8'h3C, "R7 byte in flight unchanged");
      rd(2'd1, v); chk(v, 8'hC0, "R7 flag and collision set");
      rd(2'd2, v);
      rd(2'd1, v); chk(v, 8'h00, "R6 collision cleared by sequence");

      // R5 overrun and R8 ss ignored
      wr(2'd2, 8'h11);
      ss_i = 1'b0;
      wait_idle();
      first = m_rx;
      ss_i = 1'b1;
      wr(2'd2, 8'h22);
      repeat (10) @(negedge clk);
      ss_i = 1'b0;
      wait_idle();
      @(negedge clk);
      chk(mcap, 8'h22, "R8 transfer ignores ss_i");
      rd(2'd2, v); chk(v, m_rx, "R5 second byte overwrites first");
      if (first != m_rx) chk(v != first, 1, "R5 first byte lost");
      ss_i = 1'b1;

      // R6 irq_ack clears
      ack();
      rd(2'd1, v); chk(v[7], 0, "R6 irq_ack clears flag");
      chk(irq, 0, "R6 irq low after ack");

      // R6 completion and ack in the same cycle
      wr(2'd2, 8'h5A);
      for (int i = 0; i < 400 && !(m_busy && m_cyc == 8*DIV - 1); i++) @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      rd(2'd1, v); chk(v[7], 1, "R6 completion wins over ack");
      ack();

      // R9 R10 R11 clock-following mode
      model_on = 0;
      wr(2'd0, 8'h05);
      chk({sck_oe, mosi_oe, miso_oe}, 3'b000, "R9 slave deselected pins");
      wr(2'd2, 8'hC3);
      for (int i = 0; i < 8; i++) slv_bit(1'b1, so);
      repeat (6) @(negedge clk);
      rd(2'd1, v); chk(v[7], 0, "R10 no flag while deselected");
      ss_i = 1'b0;
      repeat (4) @(negedge clk);
      chk(miso_oe, 1, "R9 miso enabled when selected");
      cap = 0;
      for (int i = 7; i >= 0; i--) begin
         slv_bit(((8'h96 >> i) & 1) != 0, so);
         cap = {cap[6:0], so};
      end
      repeat (6) @(negedge clk);
      chk(cap, 8'hC3, "R11 R10 miso carries preloaded byte");
      rd(2'd1, v); chk(v[7], 1, "R11 flag after 8 bits");
      chk(irq, 1, "R11 irq in slave mode");
      rd(2'd2, v); chk(v, 8'h96, "R11 received byte");
      ss_i = 1'b1;
      #1 chk(miso_oe, 0, "R9 miso released");

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule